// File: doc/BRIEF.md
# Open-Row Bank Timing Model

This block sits between a data cache's miss-handling registers and the memory side of a chip model. It accepts block refill and write requests, each carrying an address and the tag of the miss entry that issued it. It splits the address into column, bank and row fields and keeps one open-row register per bank. It answers each request after a short delay if the request's row is already open in its bank, or after a long delay if it is not. Each answer is a one-cycle pulse with the original tag and a flag that tells whether the access found its row open.

Accepted requests wait in a single in-order queue. The head of the queue is sent to its bank as soon as that bank is idle. Several banks can count down at the same time, so requests to different banks overlap. A bank holds one request at a time. When more than one bank finishes in the same cycle, the lowest-numbered bank answers first. The other banks stay busy and answer in later cycles, one per cycle.

Top module: `dram_row_timer`

## Requirements
- R1: An address is read as {row, bank, column}. The column is the lowest COL_W bits (11 by default, a 2 KB row), the bank index is the next BANK_W bits (2 by default, 4 banks), and the row is the top ROW_W bits (20 by default). Column bits play no part in the hit decision.
- R2: A request whose row equals its bank's open row gets rspValid with rspHit=1 exactly HIT_LAT+1 cycles after the clock edge that accepted it, when neither the queue nor the bank holds it back. HIT_LAT defaults to 100.
- R3: A request whose row differs from its bank's open row, or whose bank has no open row, gets rspValid with rspHit=0 exactly MISS_LAT+1 cycles after acceptance, under the same conditions. MISS_LAT defaults to 200.
- R4: After reset no bank has an open row, so the first access to each bank is a miss.
- R5: Every access, hit or miss, leaves its row open in its bank. A later access to a different row in that bank misses.
- R6: Every response carries on rspTag the reqTag of the request it completes.
- R7: A bank serves one request at a time. A request queued behind another to the same bank is sent to the bank in the cycle after the earlier request's response, and its own latency starts then.
- R8: Requests to different banks overlap. Two misses to two idle banks, accepted on consecutive edges, each complete MISS_LAT+1 cycles after their own acceptance.
- R9: At most one response is given per cycle. When banks finish together, the lowest bank index answers first and each other bank answers in a later cycle.
- R10: reqReady is low while QDEPTH requests are waiting. A reqValid given while reqReady is low is ignored and never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The queue can take a request this cycle |
| reqAddr | input | COL_W+BANK_W+ROW_W | Request address {row, bank, column} |
| reqTag | input | TAG_W | Miss-entry tag of the request |
| rspValid | output | 1 | One-cycle completion pulse |
| rspTag | output | TAG_W | Tag of the completed request |
| rspHit | output | 1 | 1 if the completed access found its row open |

## Verification
The bench uses a small configuration: 2-bit fields and short latencies. It sweeps every bank through every row, once with a fresh row and once repeated with a different column. This separates closed and reopened rows, which must miss, from repeated rows, which must hit, and shows that column bits play no part. It then sends back-to-back pairs to two banks and to one bank. These show overlap across banks and serialization within a bank. Two pairs are timed to finish on the same edge, in both bank orders, to expose the answer order. A burst aimed at one busy bank fills the queue. It checks the stall, the dropped extra request, and the strict spacing of the queued responses.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // Strobes the control unit hands to the datapath each cycle.
  typedef struct packed {
    logic push;     // write the incoming request into the queue
    logic pop;      // send the queue head to its bank
    logic rspFire;  // a finished bank answers this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int QDEPTH   = 4,
  parameter int HIT_LAT  = 100,
  parameter int MISS_LAT = 200,
  localparam int NBANK = 1 << BANK_W,
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CNT_W = $clog2(MISS_LAT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] headBank,
  input  logic              headHit,
  output logic              reqReady,
  output ctrl_strobe_t      strobe,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [BANK_W-1:0] rspBank
);
  logic [PTR_W:0]     qCount;
  logic [NBANK-1:0]   busy;
  logic [CNT_W-1:0]   cnt [NBANK];
  logic [NBANK-1:0]   done;
  logic               headValid;
  logic [CNT_W-1:0]   loadVal;

  assign reqReady  = (qCount != (PTR_W+1)'(QDEPTH));
  assign headValid = (qCount != '0);
  assign loadVal   = headHit ? CNT_W'(HIT_LAT - 1) : CNT_W'(MISS_LAT - 1);

  always_comb begin
    strobe.push    = reqValid && reqReady;
    strobe.pop     = headValid && !busy[headBank];
    strobe.rspFire = |done;
    rspBank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (done[i]) rspBank = BANK_W'(i);
    end
  end

  // Queue pointers and occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobe.push)
        wrPtr <= (wrPtr == PTR_W'(QDEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)
        rdPtr <= (rdPtr == PTR_W'(QDEPTH - 1)) ? '0 : rdPtr + 1'b1;
      qCount <= qCount + (PTR_W+1)'(strobe.push) - (PTR_W+1)'(strobe.pop);
    end
  end

  AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == '0) |-> !strobe.pop); // R7
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == (PTR_W+1)'(QDEPTH) && !strobe.pop) |=> (qCount == (PTR_W+1)'(QDEPTH))); // R10

  // Per-bank busy countdown
  for (genvar g = 0; g < NBANK; g++) begin : gBank
    assign done[g] = busy[g] && (cnt[g] == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busy[g] <= 1'b0;
        cnt[g]  <= '0;
      end else if (strobe.pop && headBank == BANK_W'(g)) begin
        busy[g] <= 1'b1;
        cnt[g]  <= loadVal;
      end else if (strobe.rspFire && rspBank == BANK_W'(g)) begin
        busy[g] <= 1'b0;
      end else if (busy[g] && cnt[g] != '0) begin
        cnt[g] <= cnt[g] - 1'b1;
      end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      busy[g] |-> (cnt[g] < CNT_W'(MISS_LAT))); // R3
    AST_BANK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rspFire && rspBank == BANK_W'(g)) |=> !busy[g]); // R7
  end
endmodule

// File: rtl/dram_dpath.sv
module dram_dpath
  import dram_pkg::*;
#(
  parameter int COL_W  = 11,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 20,
  parameter int TAG_W  = 2,
  parameter int QDEPTH = 4,
  localparam int NBANK  = 1 << BANK_W,
  localparam int ADDR_W = COL_W + BANK_W + ROW_W,
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [BANK_W-1:0] rspBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [BANK_W-1:0] headBank,
  output logic              headHit,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspHit
);
  logic [ADDR_W-1:0] qAddr [QDEPTH];
  logic [TAG_W-1:0]  qTag  [QDEPTH];
  logic [ROW_W-1:0]  openRow [NBANK];
  logic [NBANK-1:0]  rowValid;
  logic [TAG_W-1:0]  bankTag [NBANK];
  logic [NBANK-1:0]  bankHit;
  logic [ROW_W-1:0]  headRow;
  logic [TAG_W-1:0]  headTag;

  // Address decode of the queue head: {row, bank, column}
  assign headBank = qAddr[rdPtr][COL_W +: BANK_W];
  assign headRow  = qAddr[rdPtr][ADDR_W-1 -: ROW_W];
  assign headTag  = qTag[rdPtr];
  assign headHit  = rowValid[headBank] && (openRow[headBank] == headRow);

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      qAddr[wrPtr] <= reqAddr;
      qTag[wrPtr]  <= reqTag;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : gRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowValid[g] <= 1'b0;
        openRow[g]  <= '0;
        bankTag[g]  <= '0;
        bankHit[g]  <= 1'b0;
      end else if (strobe.pop && headBank == BANK_W'(g)) begin
        rowValid[g] <= 1'b1;
        openRow[g]  <= headRow;
        bankTag[g]  <= headTag;
        bankHit[g]  <= headHit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= '0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= strobe.rspFire;
      if (strobe.rspFire) begin
        rspTag <= bankTag[rspBank];
        rspHit <= bankHit[rspBank];
      end
    end
  end

  AST_OPEN_ROW_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.pop) |-> (rowValid[$past(headBank)] &&
                           openRow[$past(headBank)] == $past(headRow))); // R5
  AST_RSP_FROM_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(strobe.rspFire)); // R9
endmodule

// File: rtl/dram_row_timer.sv
module dram_row_timer
  import dram_pkg::*;
#(
  parameter int COL_W    = 11,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 20,
  parameter int TAG_W    = 2,
  parameter int QDEPTH   = 4,
  parameter int HIT_LAT  = 100,
  parameter int MISS_LAT = 200,
  localparam int ADDR_W = COL_W + BANK_W + ROW_W,
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspHit
);
  ctrl_strobe_t      strobe;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [BANK_W-1:0] rspBank;
  logic [BANK_W-1:0] headBank;
  logic              headHit;

  dram_ctrl #(
    .BANK_W(BANK_W), .QDEPTH(QDEPTH), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .headBank(headBank),
    .headHit(headHit), .reqReady(reqReady), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .rspBank(rspBank)
  );

  dram_dpath #(
    .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rspBank(rspBank), .reqAddr(reqAddr), .reqTag(reqTag),
    .headBank(headBank), .headHit(headHit), .rspValid(rspValid),
    .rspTag(rspTag), .rspHit(rspHit)
  );
endmodule

// File: tb/dram_row_timer_bench.sv
module dram_row_timer_bench;
  localparam int COL_W = 2, BANK_W = 2, ROW_W = 2, TAG_W = 3, QDEPTH = 4;
  localparam int HIT_LAT = 3, MISS_LAT = 6;
  localparam int ADDR_W = COL_W + BANK_W + ROW_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic rspValid;
  logic [TAG_W-1:0] rspTag;
  logic rspHit;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;
  bit got [8];
  int gotCyc [8];
  bit gotHit [8];
  int acc [8];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_row_timer #(
    .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W),
    .QDEPTH(QDEPTH), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_dram_row_timer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqTag(reqTag), .rspValid(rspValid),
    .rspTag(rspTag), .rspHit(rspHit)
  );

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      got[rspTag]    = 1'b1;
      gotCyc[rspTag] = cyc;
      gotHit[rspTag] = rspHit;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int col);
    return {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
  endfunction

  task automatic clearGot();
    for (int i = 0; i < 8; i++) got[i] = 1'b0;
  endtask

  task automatic send(input int row, input int bank, input int col, input int tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = mk(row, bank, col);
    reqTag   = TAG_W'(tag);
    acc[tag] = cyc + 1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // One isolated request: latency, hit flag and tag (R1 R2 R3 R6)
  task automatic single(input int row, input int bank, input int col, input int tag,
                        input bit expHit, input string req);
    int expLat;
    got[tag] = 1'b0;
    send(row, bank, col, tag);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      if (got[tag]) break;
    end
    expLat = expHit ? HIT_LAT + 1 : MISS_LAT + 1;
    check(got[tag], {req, " R6 tag returned"}, int'(got[tag]), 1);
    check(gotHit[tag] == expHit, {req, " hit flag"}, int'(gotHit[tag]), int'(expHit));
    check(gotCyc[tag] - acc[tag] == expLat, {req, " latency"}, gotCyc[tag] - acc[tag], expLat);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clearGot();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R4 reset rspValid", int'(rspValid), 0);
    check(reqReady == 1'b1, "R10 reset reqReady", int'(reqReady), 1);

    // Sweep: each bank, each row; fresh row misses, repeat with new column hits
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 4; r++) begin
        single(r, b, r, (2*r) % 8, 1'b0, (r == 0) ? "R4 first access" : "R5 R3 row change");
        single(r, b, 3 - r, (2*r + 1) % 8, 1'b1, "R2 R1 same row other column");
      end
    end
    // Reopen an earlier row: still a miss (R5)
    single(0, 1, 0, 0, 1'b0, "R5 old row closed");
    single(3, 1, 1, 1, 1'b0, "R5 row reopened");

    // R8: two banks overlap
    clearGot();
    send(0, 0, 0, 0);
    send(0, 1, 0, 1);
    repeat (20) @(posedge clk);
    check(gotCyc[0] - acc[0] == MISS_LAT + 1, "R8 bank0 latency", gotCyc[0] - acc[0], MISS_LAT + 1);
    check(gotCyc[1] - acc[1] == MISS_LAT + 1, "R8 bank1 latency", gotCyc[1] - acc[1], MISS_LAT + 1);

    // R7: same bank serializes
    clearGot();
    send(1, 2, 0, 2);
    send(1, 2, 2, 3);
    repeat (25) @(posedge clk);
    check(gotCyc[2] - acc[2] == MISS_LAT + 1, "R7 first latency", gotCyc[2] - acc[2], MISS_LAT + 1);
    check(gotCyc[3] == gotCyc[2] + 1 + HIT_LAT, "R7 second waits", gotCyc[3] - gotCyc[2], 1 + HIT_LAT);
    check(gotHit[3] == 1'b1, "R7 second hit", int'(gotHit[3]), 1);

    // R9: simultaneous finish, lower bank first (both orders)
    clearGot();
    send(2, 0, 0, 4);
    repeat (2) @(posedge clk);
    send(0, 1, 0, 5);
    repeat (20) @(posedge clk);
    check(gotCyc[4] == acc[4] + 7, "R9 bank0 wins", gotCyc[4] - acc[4], 7);
    check(gotCyc[5] == acc[4] + 8, "R9 bank1 after", gotCyc[5] - acc[4], 8);
    check(gotHit[5] == 1'b1 && gotHit[4] == 1'b0, "R9 hit flags", int'(gotHit[5]), 1);
    clearGot();
    send(0, 3, 0, 6);
    repeat (2) @(posedge clk);
    send(1, 2, 1, 7);
    repeat (20) @(posedge clk);
    check(gotCyc[7] == acc[6] + 7, "R9 bank2 wins", gotCyc[7] - acc[6], 7);
    check(gotCyc[6] == acc[6] + 8, "R9 bank3 after", gotCyc[6] - acc[6], 8);

    // R10: fill queue behind busy bank0, extra request ignored
    clearGot();
    for (int k = 0; k < 5; k++) begin
      check(reqReady == 1'b1, "R10 ready before fill", int'(reqReady), 1);
      send((k % 2 == 0) ? 1 : 2, 0, k % 4, k);
    end
    @(negedge clk);
    check(reqReady == 1'b0, "R10 full stalls", int'(reqReady), 0);
    reqValid = 1'b1;
    reqAddr  = mk(3, 1, 0);
    reqTag   = 3'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(reqReady == 1'b0, "R10 still full", int'(reqReady), 0);
    end
    reqValid = 1'b0;
    repeat (50) @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      check(got[k] && gotCyc[k] == acc[0] + 7 + 7*k, "R10 R7 queued response",
            gotCyc[k] - acc[0], 7 + 7*k);
      check(gotHit[k] == 1'b0, "R5 queued misses", int'(gotHit[k]), 0);
    end
    check(got[7] == 1'b0, "R10 ignored request", int'(got[7]), 0);

    summary();
  end
endmodule